// File: doc/BRIEF.md
# Reference-Counted Watch Slot Allocator

This block hands out a small pool of hardware watch slots to a single requester. Each request asks to insert or remove a watch, given an address and a 4-bit kind/size code. Identical requests share a slot, and a per-slot use count records how many times that slot has been claimed. A slot is given back only when its last user removes it.

The block keeps a mirror of every slot's address and use count, plus a packed control word. A downstream match unit decodes that word, so its bit positions are fixed. Whenever a slot is taken or freed, the block writes the control word and then that slot's address toward the match unit. It then pulses `done` with an `ok` flag. Requests that only change a use count, and requests that fail, complete on the next cycle without any register write. Per-slot hit flags coming back from the match unit are collected into a sticky status mirror.

Top module: `watch_slot_alloc`

## Requirements
- R1: An insert whose address and code both equal those of an occupied slot raises that slot's use count by one. `done` and `ok` are high in the first cycle after acceptance, and no register write is issued. A slot holding the same address under a different code does not match.
- R2: An insert with no matching slot claims the lowest-index vacant slot. A slot is vacant when its two enable bits (control bits 2i and 2i+1) are both clear.
- R3: Claiming slot i does all of the following: it stores the address, sets the use count to 1, writes the code into control bits [16+4i +: 4], sets the local enable (bit 2i) and the exact-match bit (bit 8), and forces control bits 15:10 to zero.
- R4: After a claim or a release, the block writes in a fixed order. In cycle 2 after acceptance it drives `wr_valid` with `wr_is_addr`=0 and the new control word. In cycle 3 it drives `wr_valid` with `wr_is_addr`=1 and the slot's address. In cycle 4 it raises `done` with `ok`=1.
- R5: An insert that finds neither a matching slot nor a vacant one completes with `ok`=0 in cycle 1 and changes no state.
- R6: A remove that matches a slot on both address and code lowers its use count. If the count was above 1, the remove completes in cycle 1 with no write. If the count was 1, the slot is released: both of its enable bits clear, its address clears (the address write carries 0), and the R4 write sequence follows.
- R7: A remove that matches no slot completes with `ok`=0 in cycle 1 and changes no state.
- R8: Synchronous `rst`, or the `init` command, clears all addresses, all use counts, the control word and the status mirror.
- R9: Use counts are 8 bits wide and saturate at 255. An insert on a slot whose count is 255 succeeds and leaves the count at 255.
- R10: `req_ready` is high only while the block is idle. A `req_valid` pulse seen while `req_ready` is low is ignored.
- R11: Each bit of `status_word` is set when the matching bit of `hit_in` is high and stays set until reset or `init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous clear of all slot state |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_remove | input | 1 | 0 = insert, 1 = remove |
| req_addr | input | ADDR_W | Watch address |
| req_code | input | CODE_W | Kind/size code |
| hit_in | input | NUM_SLOTS | Per-slot hit flags from the match unit |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success flag, valid with `done` |
| wr_valid | output | 1 | Register write toward the match unit |
| wr_is_addr | output | 1 | 0 = control word write, 1 = slot address write |
| wr_slot | output | SLOT_W | Slot index of the write |
| wr_data | output | DATA_W | Write data |
| ctrl_word | output | CTRL_W | Control word mirror |
| status_word | output | NUM_SLOTS | Sticky hit status mirror |

## Verification
The bench builds the block with its defaults: four slots, 32-bit addresses and control word, 8-bit use counts. With only four slots, pool exhaustion and lowest-vacant selection after out-of-order releases come up often, both in directed cases and in random traffic drawn from four addresses and three codes. The 8-bit count puts saturation within a few hundred requests, so the bench drives a slot all the way to 255 and then drains it back to release.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WCTRL, ST_WADDR, ST_DONE} wsa_state_e;
  // control word layout decoded by the match unit
  localparam int EN_STRIDE   = 2;
  localparam int EXACT_BIT   = 8;
  localparam int RSVD_LO     = 10;
  localparam int RSVD_HI     = 15;
  localparam int FIELD_BASE  = 16;
  localparam int FIELD_W     = 4;
endpackage

// File: rtl/wsa_slot_cmp.sv
module wsa_slot_cmp #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 4
) (
  input  logic [1:0]        en_bits,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [CODE_W-1:0] slot_code,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CODE_W-1:0] req_code,
  output logic              occupied,
  output logic              hit
);
  always_comb begin
    occupied = |en_bits;
    hit      = occupied && (slot_addr == req_addr) && (slot_code == req_code);
  end
endmodule

// File: rtl/wsa_lowest.sv
module wsa_lowest #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/watch_slot_alloc.sv
module watch_slot_alloc
  import wsa_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 8,
  parameter int CTRL_W    = 32,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int DATA_W   = (ADDR_W > CTRL_W) ? ADDR_W : CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_remove,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [CODE_W-1:0]    req_code,
  input  logic [NUM_SLOTS-1:0] hit_in,
  output logic                 done,
  output logic                 ok,
  output logic                 wr_valid,
  output logic                 wr_is_addr,
  output logic [SLOT_W-1:0]    wr_slot,
  output logic [DATA_W-1:0]    wr_data,
  output logic [CTRL_W-1:0]    ctrl_word,
  output logic [NUM_SLOTS-1:0] status_word
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  wsa_state_e            state_q;
  logic [ADDR_W-1:0]     addr_q [NUM_SLOTS];
  logic [CNT_W-1:0]      cnt_q  [NUM_SLOTS];
  logic [CTRL_W-1:0]     ctrl_q;
  logic [NUM_SLOTS-1:0]  stat_q;
  logic [SLOT_W-1:0]     cur_q;

  logic [NUM_SLOTS-1:0]  occ_v, hit_v;
  logic                  m_found, v_found;
  logic [SLOT_W-1:0]     m_idx, v_idx;
  logic [CTRL_W-1:0]     claim_word, release_word;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      wsa_slot_cmp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cmp (
        .en_bits  (ctrl_q[EN_STRIDE*g +: 2]),
        .slot_addr(addr_q[g]),
        .slot_code(ctrl_q[FIELD_BASE + FIELD_W*g +: CODE_W]),
        .req_addr (req_addr),
        .req_code (req_code),
        .occupied (occ_v[g]),
        .hit      (hit_v[g])
      );
      // a slot holds a nonzero use count exactly when it is enabled
      always @(posedge clk) begin
        if (!rst) AST_OCC_HAS_COUNT: assert (occ_v[g] == (cnt_q[g] != '0)); // R6
      end
    end
  endgenerate

  wsa_lowest #(.N(NUM_SLOTS)) u_pick_hit (.vec(hit_v),  .found(m_found), .idx(m_idx));
  wsa_lowest #(.N(NUM_SLOTS)) u_pick_vac (.vec(~occ_v), .found(v_found), .idx(v_idx));

  always_comb begin
    claim_word = ctrl_q;
    claim_word[EN_STRIDE*v_idx] = 1'b1;
    claim_word[EXACT_BIT] = 1'b1;
    claim_word[FIELD_BASE + FIELD_W*v_idx +: FIELD_W] = FIELD_W'(req_code);
    claim_word[RSVD_HI:RSVD_LO] = '0;
    release_word = ctrl_q;
    release_word[EN_STRIDE*m_idx +: 2] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      state_q    <= ST_IDLE;
      ctrl_q     <= '0;
      stat_q     <= '0;
      cur_q      <= '0;
      done       <= 1'b0;
      ok         <= 1'b0;
      wr_valid   <= 1'b0;
      wr_is_addr <= 1'b0;
      wr_slot    <= '0;
      wr_data    <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      done     <= 1'b0;
      wr_valid <= 1'b0;
      stat_q   <= stat_q | hit_in;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          if (!req_remove) begin
            if (m_found) begin
              if (cnt_q[m_idx] != CNT_MAX) cnt_q[m_idx] <= cnt_q[m_idx] + CNT_ONE;
              done <= 1'b1;
              ok   <= 1'b1;
            end else if (v_found) begin
              addr_q[v_idx] <= req_addr;
              cnt_q[v_idx]  <= CNT_ONE;
              ctrl_q        <= claim_word;
              cur_q         <= v_idx;
              state_q       <= ST_WCTRL;
            end else begin
              done <= 1'b1;
              ok   <= 1'b0;
            end
          end else begin
            if (m_found) begin
              if (cnt_q[m_idx] == CNT_ONE) begin
                addr_q[m_idx] <= '0;
                cnt_q[m_idx]  <= '0;
                ctrl_q        <= release_word;
                cur_q         <= m_idx;
                state_q       <= ST_WCTRL;
              end else begin
                cnt_q[m_idx] <= cnt_q[m_idx] - CNT_ONE;
                done <= 1'b1;
                ok   <= 1'b1;
              end
            end else begin
              done <= 1'b1;
              ok   <= 1'b0;
            end
          end
        end
        ST_WCTRL: begin
          wr_valid   <= 1'b1;
          wr_is_addr <= 1'b0;
          wr_slot    <= cur_q;
          wr_data    <= DATA_W'(ctrl_q);
          state_q    <= ST_WADDR;
        end
        ST_WADDR: begin
          wr_valid   <= 1'b1;
          wr_is_addr <= 1'b1;
          wr_slot    <= cur_q;
          wr_data    <= DATA_W'(addr_q[cur_q]);
          state_q    <= ST_DONE;
        end
        default: begin
          done    <= 1'b1;
          ok      <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign ctrl_word   = ctrl_q;
  assign status_word = stat_q;

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[RSVD_HI:RSVD_LO] == '0); // R3
  AST_CTRL_THEN_ADDR: assert property (@(posedge clk) disable iff (rst || init)
    (wr_valid && !wr_is_addr) |=> (wr_valid && wr_is_addr)); // R4
  AST_ADDR_THEN_DONE: assert property (@(posedge clk) disable iff (rst || init)
    (wr_valid && wr_is_addr) |=> (done && ok)); // R4
  AST_FAIL_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
    (done && !ok) |-> $stable(ctrl_q)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst || init)
    (status_word != '0) |=> ((status_word & $past(status_word)) == $past(status_word))); // R11
endmodule

// File: tb/tb_watch_slot_alloc.sv
`timescale 1ns/1ps
module tb_watch_slot_alloc;
  localparam int NS = 4;
  logic clk = 0, rst = 1, init = 0;
  logic req_valid = 0, req_remove = 0;
  logic [31:0] req_addr = 0;
  logic [3:0]  req_code = 0;
  logic [NS-1:0] hit_in = 0;
  logic req_ready, done, ok, wr_valid, wr_is_addr;
  logic [1:0] wr_slot;
  logic [31:0] wr_data, ctrl_word;
  logic [NS-1:0] status_word;

  int checks = 0, errors = 0, cyc = 0;

  watch_slot_alloc dut (
    .clk(clk), .rst(rst), .init(init), .req_valid(req_valid), .req_ready(req_ready),
    .req_remove(req_remove), .req_addr(req_addr), .req_code(req_code), .hit_in(hit_in),
    .done(done), .ok(ok), .wr_valid(wr_valid), .wr_is_addr(wr_is_addr), .wr_slot(wr_slot),
    .wr_data(wr_data), .ctrl_word(ctrl_word), .status_word(status_word));

  always #10 clk = ~clk;

  // model state
  logic [31:0] m_addr [NS];
  int          m_cnt  [NS];
  logic [31:0] m_ctrl;

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NS; i++) begin m_addr[i] = 0; m_cnt[i] = 0; end
    m_ctrl = 0;
  endtask

  // one request; inject=1 drives an extra request while the block is busy
  task automatic apply(input bit rem, input logic [31:0] a, input logic [3:0] c, input bit inject, input string tag);
    int m, v, exp_done, ctrl_c, addr_c, done_c, s;
    bit exp_ok, ok_seen;
    logic [31:0] exp_wdata, ctrl_d, addr_d;
    int exp_slot, slot_seen;
    m = -1; v = -1;
    for (int i = 0; i < NS; i++)
      if (m < 0 && m_cnt[i] != 0 && m_addr[i] == a && m_ctrl[16+4*i +: 4] == c) m = i;
    for (int i = 0; i < NS; i++)
      if (v < 0 && m_ctrl[2*i +: 2] == 2'b00) v = i;
    exp_done = 1; exp_ok = 0; exp_slot = 0; exp_wdata = 0;
    if (!rem) begin
      if (m >= 0) begin
        if (m_cnt[m] != 255) m_cnt[m]++;
        exp_ok = 1;
      end else if (v >= 0) begin
        m_addr[v] = a; m_cnt[v] = 1;
        m_ctrl[2*v] = 1; m_ctrl[8] = 1; m_ctrl[16+4*v +: 4] = c; m_ctrl[15:10] = 0;
        exp_done = 4; exp_ok = 1; exp_slot = v; exp_wdata = a;
      end
    end else if (m >= 0) begin
      exp_ok = 1;
      if (m_cnt[m] == 1) begin
        m_cnt[m] = 0; m_addr[m] = 0; m_ctrl[2*m +: 2] = 0;
        exp_done = 4; exp_slot = m; exp_wdata = 0;
      end else m_cnt[m]--;
    end
    @(negedge clk);
    req_valid = 1; req_remove = rem; req_addr = a; req_code = c;
    @(negedge clk);
    req_valid = 0;
    ctrl_c = 0; addr_c = 0; done_c = 0; ok_seen = 0; ctrl_d = 0; addr_d = 0; slot_seen = 0;
    for (s = 1; s <= 8; s++) begin
      if (inject && s == 1) begin
        req_valid = 1; req_remove = 0; req_addr = 32'hDEAD_0000; req_code = 4'h7;
      end else req_valid = 0;
      if (wr_valid && !wr_is_addr) begin ctrl_c = s; ctrl_d = wr_data; end
      if (wr_valid && wr_is_addr) begin addr_c = s; addr_d = wr_data; slot_seen = wr_slot; end
      if (done) begin done_c = s; ok_seen = ok; break; end
      @(negedge clk);
    end
    req_valid = 0;
    chk(done_c == exp_done, {tag, " done cycle"}, done_c, exp_done);
    chk(ok_seen == exp_ok, {tag, " ok"}, ok_seen, exp_ok);
    chk(ctrl_word == m_ctrl, {tag, " ctrl_word"}, ctrl_word, m_ctrl);
    if (exp_done == 4) begin
      chk(ctrl_c == 2 && ctrl_d == m_ctrl, {tag, " R4 ctrl write"}, ctrl_d, m_ctrl);
      chk(addr_c == 3 && addr_d == exp_wdata, {tag, " R4 addr write"}, addr_d, exp_wdata);
      chk(slot_seen == exp_slot, {tag, " R4 write slot"}, slot_seen, exp_slot);
    end else begin
      chk(ctrl_c == 0 && addr_c == 0, {tag, " R1 no write"}, ctrl_c + addr_c, 0);
    end
  endtask

  initial begin
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected<200000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ctrl_word == 0 && status_word == 0, "R8 reset state", ctrl_word, 0);
    chk(req_ready == 1 && done == 0 && wr_valid == 0, "R10 reset idle", {req_ready, done, wr_valid}, 3'b100);

    // claims, sharing, code mismatch
    apply(0, 32'h1000, 4'hD, 0, "R2 claim slot0");
    apply(0, 32'h1000, 4'hD, 0, "R1 share slot0");
    apply(0, 32'h1000, 4'h1, 0, "R1 code differs claims R3");
    apply(0, 32'h2000, 4'h3, 1, "R10 busy inject");
    apply(0, 32'h3000, 4'h1, 0, "R2 claim slot3");
    apply(0, 32'h4000, 4'h1, 0, "R5 full");
    apply(1, 32'h5000, 4'h1, 0, "R7 remove absent");
    apply(1, 32'h1000, 4'hD, 0, "R6 dec to 1");
    apply(1, 32'h1000, 32'hD, 0, "R6 release slot0");
    apply(1, 32'h1000, 4'h1, 0, "R6 release slot1");
    apply(0, 32'h6000, 4'h3, 0, "R2 lowest vacant");
    apply(0, 32'h4000, 4'h1, 0, "R2 next vacant");

    // status mirror
    @(negedge clk); hit_in = 4'b0010;
    @(negedge clk); hit_in = 4'b0000;
    @(negedge clk);
    chk(status_word == 4'b0010, "R11 capture", status_word, 4'b0010);
    hit_in = 4'b1000;
    @(negedge clk); hit_in = 0;
    @(negedge clk);
    chk(status_word == 4'b1010, "R11 sticky", status_word, 4'b1010);

    // init clears everything
    init = 1; @(negedge clk); init = 0; model_clear();
    @(negedge clk);
    chk(ctrl_word == 0 && status_word == 0, "R8 init clears", ctrl_word, 0);
    apply(0, 32'h0000_0040, 4'h3, 0, "R8 claim after init");
    apply(1, 32'h0000_0040, 4'h3, 0, "R8 count was one");

    // saturation
    for (int k = 0; k < 256; k++) apply(0, 32'h7770, 4'hF, 0, "R9 fill");
    for (int k = 0; k < 255; k++) apply(1, 32'h7770, 4'hF, 0, "R9 drain");
    chk(ctrl_word[1:0] == 2'b00, "R9 released after 255", ctrl_word[1:0], 0);

    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic [3:0] c;
      int r;
      a = 32'h1000 + 32'(($urandom % 4) * 4);
      r = $urandom % 3;
      c = (r == 0) ? 4'h1 : ((r == 1) ? 4'hD : 4'h3);
      apply(1'($urandom % 2), a, c, 1'($urandom % 8 == 0), "R1 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule